// File: doc/BRIEF.md
# RAM-Descriptor Single-Unit DMA Engine

This engine moves data for several channels but keeps no per-channel state in flip-flops apart from a pending bit. Each channel's control record is a three-word descriptor held in shared RAM. The engine locates and reads the descriptor each time one of the channel's triggers is served. It then copies one data unit from the source address to the destination address. Next it advances both addresses and counts the transfer counter down. Finally it writes all three descriptor words back.

Descriptor reads, data reads, data writes and write-backs all go through one memory master port with a request/acknowledge handshake. Hardware triggers finish with a cycle that pulses per-channel clear strobes for the interrupt-factor flag, the DMA request bit and the DMA enable bit, which live outside the engine. Software triggers skip that cycle.

Triggers that arrive while the engine is working are remembered per channel. Once the engine is idle, they are served lowest channel number first.

Top module: `ram_desc_dma`

## Requirements
- R1: On serving channel c, the engine reads three consecutive words at byte addresses B+12c, B+12c+4 and B+12c+8, where B is `base_addr`. It reads them in that order.
- R2: Descriptor word 0 holds the counter in bits [23:0], the mode in [25:24], the interrupt-enable bit in [26] and the size in [28:27] (00 byte, 01 halfword, other word). Words 1 and 2 hold the source and destination byte addresses in bits [27:0] and an address mode in [29:28] (00 fixed, 01 increment, 10 decrement, 11 fixed).
- R3: With mode 00, one trigger causes exactly one source read of the aligned word, then one destination write. A byte goes from source lane addr[1:0] to destination lane addr[1:0]. It is replicated on all four lanes, with a single byte-enable bit. A halfword uses lane pair addr[1] on both sides, is replicated twice, and has enables 0011 or 1100. A word is copied whole with enables 1111.
- R4: After the destination write, the counter is decremented by one, modulo 2^24. Each address moves by the unit size in bytes according to its address mode. The three updated words are written back with all enables set, in order word 0, word 1, word 2.
- R5: For a hardware trigger with a nonzero counter after the update, only the channel's flag-clear strobe pulses.
- R6: For a hardware trigger with a counter of zero and interrupt enable 1, only the request-clear strobe pulses. The flag stays set.
- R7: For a hardware trigger with a counter of zero and interrupt enable 0, the flag-clear and enable-clear strobes pulse, and the request bit is untouched.
- R8: A software trigger pulses no clear strobe.
- R9: If the descriptor mode is not 00, no access follows the three descriptor reads and no strobe pulses.
- R10: Pending triggers are served in ascending channel order. `busy` is high from the cycle after a trigger is accepted until the last step of its service.
- R11: During reset, `busy`, `mem_req` and all strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_valid | input | 1 | Trigger strobe, one cycle per trigger |
| trig_chan | input | CHW | Channel number of the trigger |
| trig_hw | input | 1 | 1 for a hardware trigger, 0 for a software trigger |
| base_addr | input | 32 | Byte address of the descriptor table |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 for write, 0 for read |
| mem_addr | output | 32 | Word-aligned byte address |
| mem_wdata | output | 32 | Write data |
| mem_be | output | 4 | Byte enables for writes |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| mem_ack | input | 1 | Access completes in this cycle |
| flag_clr_o | output | NCH | Per-channel interrupt-flag clear pulse |
| req_clr_o | output | NCH | Per-channel DMA-request clear pulse |
| en_clr_o | output | NCH | Per-channel DMA-enable clear pulse |
| busy_o | output | 1 | Engine has accepted or is serving a trigger |

## Verification
The bench uses a zero-wait memory that acknowledges every access in the cycle it is requested. Counting from the edge that accepts a trigger, the descriptor reads therefore fall in the cycles after edges 1 to 3 and the source read after edge 4. The destination write follows edge 5, the write-backs follow edges 6 to 8, and the strobes follow edge 9. The engine is idle after edge 10.

The bench does not wait for fixed counts. Its monitor samples the bus on the falling edge of every cycle in which `mem_req` is high and compares each access, in order, against a queue that the driver filled beforehand. This keeps the checks correct even when queued triggers stretch the busy period. The external flag, request and enable bits are modelled from the strobes and compared only once `busy` has dropped.

// File: rtl/ram_desc_dma_pkg.sv
package ram_desc_dma_pkg;
  localparam int WORD_W = 32;
  localparam int ADDR_W = 28;
  localparam int CNT_W  = 24;
  localparam int DESC_BYTES = 12;

  typedef enum logic [3:0] {
    S_IDLE, S_LD0, S_LD1, S_LD2, S_RD, S_WR, S_SV0, S_SV1, S_SV2, S_INT
  } st_t;

  typedef enum logic [1:0] {
    AM_FIX = 2'b00, AM_INC = 2'b01, AM_DEC = 2'b10, AM_RSV = 2'b11
  } amode_t;

  // descriptor word 0
  typedef struct packed {
    logic [2:0]       rsvd;
    logic [1:0]       size;
    logic             ie;
    logic [1:0]       mode;
    logic [CNT_W-1:0] cnt;
  } ctl_t;

  // descriptor words 1 and 2
  typedef struct packed {
    logic [1:0]        rsvd;
    amode_t            am;
    logic [ADDR_W-1:0] addr;
  } ptr_t;

  function automatic logic [2:0] unit_bytes(input logic [1:0] size);
    case (size)
      2'b00:   return 3'd1;
      2'b01:   return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

  function automatic logic [ADDR_W-1:0] step_addr(input logic [ADDR_W-1:0] a,
                                                  input amode_t m,
                                                  input logic [1:0] size);
    logic [ADDR_W-1:0] u;
    u = ADDR_W'(unit_bytes(size));
    case (m)
      AM_INC:  return a + u;
      AM_DEC:  return a - u;
      default: return a;
    endcase
  endfunction
endpackage

// File: rtl/ram_desc_dma_pend.sv
module ram_desc_dma_pend #(
  parameter int NCH = 4,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           trig_valid,
  input  logic [CHW-1:0] trig_chan,
  input  logic           trig_hw,
  input  logic           take,
  output logic           any_o,
  output logic [CHW-1:0] sel_o,
  output logic           sel_hw_o
);
  logic [NCH-1:0] pend_q, hw_q, set_m, clr_m;

  always_comb begin
    set_m = trig_valid ? (NCH'(1) << trig_chan) : '0;
    clr_m = take ? (NCH'(1) << sel_o) : '0;
  end

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pend_q[g] <= 1'b0;
        hw_q[g]   <= 1'b0;
      end else if (set_m[g] || clr_m[g]) begin
        pend_q[g] <= set_m[g];
        if (set_m[g]) hw_q[g] <= trig_hw;
      end
    end
  end

  // lowest pending channel wins
  always_comb begin
    sel_o    = '0;
    sel_hw_o = 1'b0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (pend_q[i]) begin
        sel_o    = CHW'(i);
        sel_hw_o = hw_q[i];
      end
    end
  end

  assign any_o = |pend_q;

  // R10
  pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (any_o && !take) |=> any_o);
endmodule

// File: rtl/ram_desc_dma_lane.sv
module ram_desc_dma_lane
  import ram_desc_dma_pkg::*;
(
  input  logic [1:0]        size,
  input  logic [1:0]        src_lo,
  input  logic [1:0]        dst_lo,
  input  logic [WORD_W-1:0] rdata,
  output logic [WORD_W-1:0] wdata,
  output logic [3:0]        be
);
  logic [WORD_W-1:0] bsh, hsh;

  always_comb begin
    bsh = rdata >> {src_lo, 3'b000};
    hsh = rdata >> {src_lo[1], 4'b0000};
    case (size)
      2'b00: begin
        wdata = {4{bsh[7:0]}};
        be    = 4'b0001 << dst_lo;
      end
      2'b01: begin
        wdata = {2{hsh[15:0]}};
        be    = 4'b0011 << {dst_lo[1], 1'b0};
      end
      default: begin
        wdata = rdata;
        be    = 4'b1111;
      end
    endcase
  end
endmodule

// File: rtl/ram_desc_dma.sv
module ram_desc_dma
  import ram_desc_dma_pkg::*;
#(
  parameter int NCH = 4,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trig_valid,
  input  logic [CHW-1:0]    trig_chan,
  input  logic              trig_hw,
  input  logic [WORD_W-1:0] base_addr,
  output logic              mem_req,
  output logic              mem_we,
  output logic [WORD_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  output logic [3:0]        mem_be,
  input  logic [WORD_W-1:0] mem_rdata,
  input  logic              mem_ack,
  output logic [NCH-1:0]    flag_clr_o,
  output logic [NCH-1:0]    req_clr_o,
  output logic [NCH-1:0]    en_clr_o,
  output logic              busy_o
);
  st_t               st_q, st_d;
  logic [CHW-1:0]    ch_q, ch_d, p_chan;
  logic              hw_q, hw_d, p_any, p_hw, take;
  logic [WORD_W-1:0] w0_q, w1_q, w2_q, dat_q;
  logic [WORD_W-1:0] w0_d, w1_d, w2_d, dat_d;
  logic [WORD_W-1:0] dbase, lane_wdata;
  logic [3:0]        lane_be;
  ctl_t              ctl, ctl_n;
  ptr_t              sp, dp, sp_n, dp_n;
  logic              ld_en;

  ram_desc_dma_pend #(.NCH(NCH)) u_pend (
    .clk(clk), .rst_n(rst_n), .trig_valid(trig_valid), .trig_chan(trig_chan),
    .trig_hw(trig_hw), .take(take), .any_o(p_any), .sel_o(p_chan), .sel_hw_o(p_hw)
  );

  assign ctl   = ctl_t'(w0_q);
  assign sp    = ptr_t'(w1_q);
  assign dp    = ptr_t'(w2_q);
  assign dbase = base_addr + WORD_W'(ch_q) * WORD_W'(DESC_BYTES);

  ram_desc_dma_lane u_lane (
    .size(ctl.size), .src_lo(sp.addr[1:0]), .dst_lo(dp.addr[1:0]),
    .rdata(dat_q), .wdata(lane_wdata), .be(lane_be)
  );

  always_comb begin
    ctl_n      = ctl;
    ctl_n.cnt  = ctl.cnt - CNT_W'(1);
    sp_n       = sp;
    sp_n.addr  = step_addr(sp.addr, sp.am, ctl.size);
    dp_n       = dp;
    dp_n.addr  = step_addr(dp.addr, dp.am, ctl.size);
  end

  // next-state process
  always_comb begin
    st_d = st_q;  ch_d = ch_q;  hw_d = hw_q;
    w0_d = w0_q;  w1_d = w1_q;  w2_d = w2_q;  dat_d = dat_q;
    take = 1'b0;
    mem_req = 1'b0;  mem_we = 1'b0;  mem_addr = '0;  mem_wdata = '0;  mem_be = 4'hF;
    flag_clr_o = '0;  req_clr_o = '0;  en_clr_o = '0;
    case (st_q)
      S_IDLE: if (p_any) begin
        take = 1'b1;  ch_d = p_chan;  hw_d = p_hw;  st_d = S_LD0;
      end
      S_LD0: begin
        mem_req = 1'b1;  mem_addr = dbase;
        if (mem_ack) begin w0_d = mem_rdata; st_d = S_LD1; end
      end
      S_LD1: begin
        mem_req = 1'b1;  mem_addr = dbase + 32'd4;
        if (mem_ack) begin w1_d = mem_rdata; st_d = S_LD2; end
      end
      S_LD2: begin
        mem_req = 1'b1;  mem_addr = dbase + 32'd8;
        if (mem_ack) begin
          w2_d = mem_rdata;
          st_d = (ctl.mode == 2'b00) ? S_RD : S_IDLE;
        end
      end
      S_RD: begin
        mem_req = 1'b1;  mem_addr = {4'b0, sp.addr[ADDR_W-1:2], 2'b00};
        if (mem_ack) begin dat_d = mem_rdata; st_d = S_WR; end
      end
      S_WR: begin
        mem_req = 1'b1;  mem_we = 1'b1;  mem_addr = {4'b0, dp.addr[ADDR_W-1:2], 2'b00};
        mem_wdata = lane_wdata;  mem_be = lane_be;
        if (mem_ack) begin w0_d = ctl_n; w1_d = sp_n; w2_d = dp_n; st_d = S_SV0; end
      end
      S_SV0: begin
        mem_req = 1'b1;  mem_we = 1'b1;  mem_addr = dbase;  mem_wdata = w0_q;
        if (mem_ack) st_d = S_SV1;
      end
      S_SV1: begin
        mem_req = 1'b1;  mem_we = 1'b1;  mem_addr = dbase + 32'd4;  mem_wdata = w1_q;
        if (mem_ack) st_d = S_SV2;
      end
      S_SV2: begin
        mem_req = 1'b1;  mem_we = 1'b1;  mem_addr = dbase + 32'd8;  mem_wdata = w2_q;
        if (mem_ack) st_d = hw_q ? S_INT : S_IDLE;
      end
      S_INT: begin
        if (ctl.cnt != '0) begin
          flag_clr_o[ch_q] = 1'b1;
        end else if (ctl.ie) begin
          req_clr_o[ch_q] = 1'b1;
        end else begin
          flag_clr_o[ch_q] = 1'b1;
          en_clr_o[ch_q]   = 1'b1;
        end
        st_d = S_IDLE;
      end
      default: st_d = S_IDLE;
    endcase
  end

  assign ld_en  = (st_q != S_IDLE) || p_any;
  assign busy_o = (st_q != S_IDLE) || p_any;

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= S_IDLE;  ch_q <= '0;  hw_q <= 1'b0;
      w0_q <= '0;  w1_q <= '0;  w2_q <= '0;  dat_q <= '0;
    end else begin
      st_q <= st_d;
      if (ld_en) begin
        ch_q <= ch_d;  hw_q <= hw_d;
        w0_q <= w0_d;  w1_q <= w1_d;  w2_q <= w2_d;  dat_q <= dat_d;
      end
    end
  end

  // R10
  trig_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trig_valid |=> busy_o);
  // R5
  clr_one_chan_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(flag_clr_o | req_clr_o | en_clr_o));
  // R6
  req_en_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|req_clr_o) |-> !(|en_clr_o) && !(|flag_clr_o));
  // R3
  unit_be_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_WR) |-> ($countones(mem_be) == int'(unit_bytes(ctl.size))));
endmodule

// File: tb/sim_ram_desc_dma.sv
module sim_ram_desc_dma;
  import ram_desc_dma_pkg::*;
  localparam int NCH = 4;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, trig_valid, trig_hw, mem_req, mem_we, mem_ack, busy_o;
  logic [1:0]  trig_chan;
  logic [31:0] base_addr, mem_addr, mem_wdata, mem_rdata;
  logic [3:0]  mem_be;
  logic [NCH-1:0] flag_clr_o, req_clr_o, en_clr_o;

  ram_desc_dma #(.NCH(NCH)) u0 (
    .clk(clk), .rst_n(rst_n), .trig_valid(trig_valid), .trig_chan(trig_chan),
    .trig_hw(trig_hw), .base_addr(base_addr), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_be(mem_be),
    .mem_rdata(mem_rdata), .mem_ack(mem_ack), .flag_clr_o(flag_clr_o),
    .req_clr_o(req_clr_o), .en_clr_o(en_clr_o), .busy_o(busy_o)
  );

  logic [31:0] mem [0:255];
  logic        tb_we;
  logic [7:0]  tb_idx;
  logic [31:0] tb_dat;

  assign mem_ack   = mem_req;
  assign mem_rdata = mem[mem_addr[9:2]];

  always @(posedge clk) begin
    if (tb_we) mem[tb_idx] <= tb_dat;
    else if (mem_req && mem_we)
      for (int b = 0; b < 4; b++)
        if (mem_be[b]) mem[mem_addr[9:2]][8*b +: 8] <= mem_wdata[8*b +: 8];
  end

  logic set_all;
  logic [NCH-1:0] flag_m, req_m, en_m;
  always @(posedge clk) begin
    if (set_all) begin
      flag_m <= '1;  req_m <= '1;  en_m <= '1;
    end else begin
      flag_m <= flag_m & ~flag_clr_o;
      req_m  <= req_m & ~req_clr_o;
      en_m   <= en_m & ~en_clr_o;
    end
  end

  typedef struct {
    logic        we;
    logic [31:0] addr;
    logic [31:0] data;
    logic [3:0]  be;
    string       tag;
  } acc_t;
  acc_t expq[$];

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  logic [31:0] d0 [NCH], d1 [NCH], d2 [NCH];
  logic [NCH-1:0] e_flag, e_req, e_en;

  // monitor: compares every bus access against the scoreboard queue
  always @(negedge clk) begin
    acc_t e;
    if (rst_n && mem_req) begin
      checks++;
      if (expq.size() == 0) begin
        errors++;
        $display("FAIL R9 unexpected access got we=%b addr=%h expected none", mem_we, mem_addr);
      end else begin
        e = expq.pop_front();
        if (mem_we !== e.we || mem_addr !== e.addr ||
            (e.we && (mem_wdata !== e.data || mem_be !== e.be))) begin
          errors++;
          $display("FAIL %s got we=%b addr=%h data=%h be=%h expected we=%b addr=%h data=%h be=%h",
                   e.tag, mem_we, mem_addr, mem_wdata, mem_be, e.we, e.addr, e.data, e.be);
        end
      end
    end
    if (rst_n && |(flag_clr_o | req_clr_o | en_clr_o)) begin
      checks++;
      if (!busy_o) begin
        errors++;
        $display("FAIL R10 busy during strobe got %b expected 1", busy_o);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog got running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic put(input logic [7:0] idx, input logic [31:0] dat);
    @(negedge clk);
    tb_we = 1'b1;  tb_idx = idx;  tb_dat = dat;
    @(negedge clk);
    tb_we = 1'b0;
  endtask

  task automatic setd(input int ch, input logic [23:0] cnt, input logic ie,
                      input logic [1:0] mode, input logic [1:0] sz,
                      input logic [27:0] sa, input logic [1:0] sm,
                      input logic [27:0] da, input logic [1:0] dm);
    d0[ch] = {3'b0, sz, ie, mode, cnt};
    d1[ch] = {2'b0, sm, sa};
    d2[ch] = {2'b0, dm, da};
    put(8'(64 + 3*ch), d0[ch]);
    put(8'(65 + 3*ch), d1[ch]);
    put(8'(66 + 3*ch), d2[ch]);
  endtask

  function automatic logic [27:0] nxt(input logic [27:0] a, input logic [1:0] m, input logic [1:0] sz);
    logic [27:0] u;
    u = (sz == 2'b00) ? 28'd1 : (sz == 2'b01) ? 28'd2 : 28'd4;
    if (m == 2'b01) return a + u;
    if (m == 2'b10) return a - u;
    return a;
  endfunction

  // driver side: push the expected accesses and outcome of one service
  task automatic plan(input int ch, input logic hw);
    logic [31:0] db, w, sh, data;
    logic [27:0] sa, da;
    logic [1:0]  sz;
    logic [3:0]  be;
    logic [23:0] cn;
    db = 32'h100 + 32'(ch * 12);
    expq.push_back('{1'b0, db,         32'h0, 4'h0, "R1"});
    expq.push_back('{1'b0, db + 32'd4, 32'h0, 4'h0, "R1"});
    expq.push_back('{1'b0, db + 32'd8, 32'h0, 4'h0, "R1"});
    if (d0[ch][25:24] != 2'b00) return;
    sa = d1[ch][27:0];  da = d2[ch][27:0];  sz = d0[ch][28:27];
    w = mem[sa[9:2]];
    if (sz == 2'b00) begin
      sh = w >> (8 * sa[1:0]);  data = {4{sh[7:0]}};  be = 4'b0001 << da[1:0];
    end else if (sz == 2'b01) begin
      sh = w >> (16 * sa[1]);   data = {2{sh[15:0]}}; be = da[1] ? 4'b1100 : 4'b0011;
    end else begin
      data = w;  be = 4'hF;
    end
    expq.push_back('{1'b0, {4'b0, sa[27:2], 2'b00}, 32'h0, 4'h0, "R3 source read"});
    expq.push_back('{1'b1, {4'b0, da[27:2], 2'b00}, data, be, "R3 destination write"});
    cn = d0[ch][23:0] - 24'd1;
    d0[ch][23:0] = cn;
    d1[ch][27:0] = nxt(sa, d1[ch][29:28], sz);
    d2[ch][27:0] = nxt(da, d2[ch][29:28], sz);
    expq.push_back('{1'b1, db,         d0[ch], 4'hF, "R4 word0 save"});
    expq.push_back('{1'b1, db + 32'd4, d1[ch], 4'hF, "R4 word1 save"});
    expq.push_back('{1'b1, db + 32'd8, d2[ch], 4'hF, "R4 word2 save"});
    if (hw) begin
      if (cn != 24'd0) e_flag[ch] = 1'b0;
      else if (d0[ch][26]) e_req[ch] = 1'b0;
      else begin e_flag[ch] = 1'b0; e_en[ch] = 1'b0; end
    end
  endtask

  task automatic arm();
    @(negedge clk);  set_all = 1'b1;
    @(negedge clk);  set_all = 1'b0;
    e_flag = '1;  e_req = '1;  e_en = '1;
  endtask

  task automatic trig(input int ch, input logic hw);
    @(negedge clk);
    trig_valid = 1'b1;  trig_chan = 2'(ch);  trig_hw = hw;
    @(negedge clk);
    trig_valid = 1'b0;
    checks++;
    if (busy_o !== 1'b1) begin
      errors++;
      $display("FAIL R10 busy after trigger got %b expected 1", busy_o);
    end
  endtask

  task automatic settle(input string tag);
    int n;
    n = 0;
    while (busy_o && n < 200) begin @(negedge clk); n++; end
    @(negedge clk);
    checks++;
    if (busy_o || expq.size() != 0) begin
      errors++;
      $display("FAIL %s completion got busy=%b left=%0d expected busy=0 left=0", tag, busy_o, expq.size());
      expq.delete();
    end
    checks++;
    if (flag_m !== e_flag || req_m !== e_req || en_m !== e_en) begin
      errors++;
      $display("FAIL %s bits got flag=%b req=%b en=%b expected flag=%b req=%b en=%b",
               tag, flag_m, req_m, en_m, e_flag, e_req, e_en);
    end
  endtask

  initial begin
    rst_n = 1'b0;  trig_valid = 1'b0;  trig_chan = '0;  trig_hw = 1'b0;
    tb_we = 1'b0;  tb_idx = '0;  tb_dat = '0;  set_all = 1'b0;
    base_addr = 32'h100;
    for (int i = 0; i < 256; i++) put(8'(i), 32'(i) * 32'h0103_0507 ^ 32'hA5C3_5A3C);
    @(negedge clk);
    // R11 reset state
    checks++;
    if (busy_o !== 1'b0 || mem_req !== 1'b0 || (flag_clr_o | req_clr_o | en_clr_o) !== '0) begin
      errors++;
      $display("FAIL R11 reset got busy=%b req=%b expected 0 0", busy_o, mem_req);
    end
    @(negedge clk);  rst_n = 1'b1;

    // R5 / R2 byte increment, counter 3 -> 2
    setd(0, 24'd3, 1'b1, 2'b00, 2'b00, 28'h011, 2'b01, 28'h202, 2'b01);
    arm();  plan(0, 1'b1);  trig(0, 1'b1);  settle("R5 nonzero count");
    arm();  plan(0, 1'b1);  trig(0, 1'b1);  settle("R4 second unit");
    // R6 counter reaches zero with interrupt enabled
    arm();  plan(0, 1'b1);  trig(0, 1'b1);  settle("R6 zero count ie=1");
    // R7 halfword, decrement source, fixed destination
    setd(1, 24'd1, 1'b0, 2'b00, 2'b01, 28'h022, 2'b10, 28'h206, 2'b00);
    arm();  plan(1, 1'b1);  trig(1, 1'b1);  settle("R7 zero count ie=0");
    // R8 software trigger, word unit, decrement destination
    setd(2, 24'd1, 1'b0, 2'b00, 2'b10, 28'h030, 2'b01, 28'h210, 2'b10);
    arm();  plan(2, 1'b0);  trig(2, 1'b0);  settle("R8 software");
    // R9 mode field not 00
    setd(3, 24'd4, 1'b0, 2'b01, 2'b00, 28'h040, 2'b01, 28'h220, 2'b01);
    arm();  plan(3, 1'b1);  trig(3, 1'b1);  settle("R9 other mode");
    // R10 queued triggers served lowest channel first
    setd(3, 24'd5, 1'b0, 2'b00, 2'b00, 28'h041, 2'b01, 28'h220, 2'b01);
    setd(1, 24'd2, 1'b1, 2'b00, 2'b01, 28'h052, 2'b01, 28'h230, 2'b01);
    arm();
    plan(3, 1'b0);  plan(1, 1'b1);  plan(2, 1'b1);
    trig(3, 1'b0);  trig(2, 1'b1);  trig(1, 1'b1);
    settle("R10 ascending order");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule